// File: doc/BRIEF.md
# Cascaded Memory-Mapped Interrupt Controller

This block gathers interrupt requests from a primary bank of 40 lines and a secondary bank of 32 lines and presents them to a processor as one combined request. External sources pass through a synchronizer. A rising edge on a synchronized source sets a pending flag, which stays set until software acknowledges it. Every line also has an enable flag. Only lines that are both pending and enabled take part in arbitration and drive the processor request.

The secondary bank has no output of its own. The OR of its pending-and-enabled lines is the source of primary line 0, and a rising edge of that OR sets line 0's pending flag. Software reaches the block over a simple 32-bit register bus with an address, write data, a write strobe, a read strobe and registered read data. Enable and pending state change only through write-one-to-set and write-one-to-clear addresses, so no read-modify-write sequence is needed. A priority index register gives the number of the winning primary line directly. A table of per-channel source-number words is also provided, one word per primary channel; it is storage only and does not route any request.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, all enable and pending flags read 0, the index register reads 63, and `irq_o` is 0.
- R2: A primary source that rises and stays high sets its pending flag at the third rising clock edge after the change. The flag stays set while the source stays high. Once cleared, it is set again only by a new rising edge of the source.
- R3: A write of 1 to a bit at 0x20 (word 0) or 0x24 (word 1) enables that line. A write of 1 at 0x30 or 0x34 disables it. Zero bits change nothing. A read of either address of a word returns that word's enable flags.
- R4: Primary line n sits in word n/32 at bit n%32, so word 1 uses only bits 7:0 and reads 0 above them. A read of 0x10 or 0x14 returns the pending flags of that word. A write of 1 to a bit there clears that pending flag.
- R5: When a pending clear and a new rising edge hit the same line in the same cycle, the line stays pending.
- R6: A read of 0x40 returns, in bits 5:0, the lowest line number that is both pending and enabled, with all upper bits 0. It reads 63 when no line qualifies.
- R7: `irq_o` is high exactly when at least one primary line is both pending and enabled. A pending line that is disabled does not drive it.
- R8: The secondary bank returns its pending flags at 0x80. A write of 1 at 0x88 clears a pending flag, at 0x90 enables a line and at 0x98 disables a line. Reads of 0x90 and 0x98 return the secondary enables. Secondary sources are latched the same way as primary sources.
- R9: A rising edge of the OR of all pending-and-enabled secondary lines sets primary line 0's pending flag one clock later. Line 0 has no external source.
- R10: Channel word n is at 0x200 + 4n for n from 0 to 39. It holds a 6-bit source number in bits 5:0 that resets to n, can be written, and reads 0 in bits 31:6.
- R11: A write to any address not listed above changes no state. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pri_src_i | input | 39 | Primary sources for lines 39..1, bit index equals line number |
| sec_src_i | input | 32 | Secondary sources, bit index equals secondary line number |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe; data appears after the next rising edge |
| bus_rdata_o | output | 32 | Registered read data, held between reads |
| irq_o | output | 1 | Combined request to the processor |

## Verification
Arbitration is tested with one line alone, a word-0 line against a word-1 line, and three lines raised together and then acknowledged one by one. These cases show whether the lowest-number rule holds across the word boundary and whether the index moves to the next line after each clear. Sources that stay high after an acknowledge show whether the design latches on edges or on levels. A clear timed to land in the cycle of a fresh edge shows which of the two takes precedence. The cascade is tried with a secondary line pending but not yet enabled, and then enabled. This shows that only the enabled OR, not the raw secondary pending flags, reaches primary line 0.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // register offsets that software depends on
   localparam int PEND_BASE   = 'h010;
   localparam int EN_SET_BASE = 'h020;
   localparam int EN_CLR_BASE = 'h030;
   localparam int INDEX_ADDR  = 'h040;
   localparam int SEC_STATUS  = 'h080;
   localparam int SEC_PCLR    = 'h088;
   localparam int SEC_ESET    = 'h090;
   localparam int SEC_ECLR    = 'h098;
   localparam int MAP_BASE    = 'h200;
   localparam int WORD_BITS   = 32;
   localparam int WORD_BYTES  = 4;
endpackage

// File: rtl/irqc_sync_edge.sv
module irqc_sync_edge #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level_i,
   output logic [WIDTH-1:0] rise_o
);
   logic [WIDTH-1:0] synced;
   logic [WIDTH-1:0] prev_q;

   generate
      if (STAGES < 0) begin : g_bad
         $error("irqc_sync_edge: STAGES must be non-negative");
      end
      if (STAGES == 0) begin : g_direct
         assign synced = level_i;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= level_i;
               for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
            end
         end
         assign synced = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= synced;
   end

   assign rise_o = synced & ~prev_q;
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] rise_i,
   input  logic [WIDTH-1:0] pend_clr_i,
   input  logic [WIDTH-1:0] en_set_i,
   input  logic [WIDTH-1:0] en_clr_i,
   output logic [WIDTH-1:0] pend_o,
   output logic [WIDTH-1:0] en_o,
   output logic [WIDTH-1:0] active_o
);
   logic [WIDTH-1:0] pend_q;
   logic [WIDTH-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         en_q   <= '0;
      end else begin
         // a fresh edge outranks an acknowledge in the same cycle
         pend_q <= (pend_q & ~pend_clr_i) | rise_i;
         en_q   <= (en_q | en_set_i) & ~en_clr_i;
      end
   end

   assign pend_o   = pend_q;
   assign en_o     = en_q;
   assign active_o = pend_q & en_q;

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_clr_i & ~rise_i)) |=> ((pend_q & $past(pend_clr_i & ~rise_i)) == '0));

   assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise_i) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));

   assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(en_set_i & ~en_clr_i)) |=> ((en_q & $past(en_set_i & ~en_clr_i)) == $past(en_set_i & ~en_clr_i)));

   assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|en_clr_i) |=> ((en_q & $past(en_clr_i)) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int WIDTH = 40,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] req_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             valid_o
);
   localparam logic [IDX_W-1:0] IDLE_IDX = '1;

   generate
      if (WIDTH >= (1 << IDX_W)) begin : g_bad
         $error("irqc_prio: IDX_W too narrow for WIDTH");
      end
   endgenerate

   always_comb begin
      idx_o   = IDLE_IDX;
      valid_o = 1'b0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            idx_o   = IDX_W'(i);
            valid_o = 1'b1;
         end
      end
   end

   assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i == '0) |-> (idx_o == IDLE_IDX && !valid_o));

   assert_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (int'(idx_o) < WIDTH && req_i[idx_o]));
endmodule

// File: rtl/irqc_chan_map.sv
module irqc_chan_map #(
   parameter int NUM_CH  = 40,
   parameter int FIELD_W = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic [$clog2(NUM_CH)-1:0] wr_sel_i,
   input  logic [FIELD_W-1:0]        wr_data_i,
   input  logic [$clog2(NUM_CH)-1:0] rd_sel_i,
   output logic [FIELD_W-1:0]        rd_data_o
);
   localparam int SEL_W = $clog2(NUM_CH);

   logic [NUM_CH-1:0][FIELD_W-1:0] map_q;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               map_q[ch] <= FIELD_W'(ch);
            else if (wr_en_i && wr_sel_i == SEL_W'(ch))
               map_q[ch] <= wr_data_i;
         end
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      for (int ch = 0; ch < NUM_CH; ch++)
         if (rd_sel_i == SEL_W'(ch)) rd_data_o = map_q[ch];
   end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_PRI     = 40,
   parameter int NUM_SEC     = 32,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 12,
   parameter int IDX_W       = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_PRI-1:1] pri_src_i,
   input  logic [NUM_SEC-1:0] sec_src_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [31:0]        bus_wdata_i,
   input  logic               bus_wr_i,
   input  logic               bus_rd_i,
   output logic [31:0]        bus_rdata_o,
   output logic               irq_o
);
   localparam int PRI_WORDS = (NUM_PRI + WORD_BITS - 1) / WORD_BITS;
   localparam int PAD_W     = PRI_WORDS * WORD_BITS;
   localparam int SEL_W     = $clog2(NUM_PRI);
   localparam int MAP_END   = MAP_BASE + WORD_BYTES * NUM_PRI;

   generate
      if (NUM_PRI < 2 || PRI_WORDS > 4) begin : g_bad_pri
         $error("cascade_irq_ctrl: NUM_PRI must be 2..128");
      end
      if (NUM_SEC < 1 || NUM_SEC > WORD_BITS) begin : g_bad_sec
         $error("cascade_irq_ctrl: NUM_SEC must be 1..32");
      end
      if (MAP_END > (1 << ADDR_W)) begin : g_bad_addr
         $error("cascade_irq_ctrl: ADDR_W too narrow for the channel table");
      end
      if (IDX_W > WORD_BITS) begin : g_bad_idx
         $error("cascade_irq_ctrl: IDX_W too wide");
      end
   endgenerate

   // ---------------- source edge capture ----------------
   logic [NUM_PRI-1:1] pri_rise_ext;
   logic [NUM_SEC-1:0] sec_rise;
   logic               casc_rise;
   logic               sec_any;

   irqc_sync_edge #(.WIDTH(NUM_PRI - 1), .STAGES(SYNC_STAGES)) u_pri_sync (
      .clk(clk), .rst_n(rst_n), .level_i(pri_src_i), .rise_o(pri_rise_ext));

   irqc_sync_edge #(.WIDTH(NUM_SEC), .STAGES(SYNC_STAGES)) u_sec_sync (
      .clk(clk), .rst_n(rst_n), .level_i(sec_src_i), .rise_o(sec_rise));

   // cascade level is internal, already in this clock domain
   irqc_sync_edge #(.WIDTH(1), .STAGES(0)) u_casc_edge (
      .clk(clk), .rst_n(rst_n), .level_i(sec_any), .rise_o(casc_rise));

   // ---------------- write decode ----------------
   logic [NUM_PRI-1:0] pri_pclr, pri_eset, pri_eclr;
   logic [NUM_SEC-1:0] sec_pclr, sec_eset, sec_eclr;

   always_comb begin
      for (int i = 0; i < NUM_PRI; i++) begin
         pri_pclr[i] = bus_wr_i && bus_wdata_i[i % WORD_BITS] &&
                       bus_addr_i == ADDR_W'(PEND_BASE + WORD_BYTES * (i / WORD_BITS));
         pri_eset[i] = bus_wr_i && bus_wdata_i[i % WORD_BITS] &&
                       bus_addr_i == ADDR_W'(EN_SET_BASE + WORD_BYTES * (i / WORD_BITS));
         pri_eclr[i] = bus_wr_i && bus_wdata_i[i % WORD_BITS] &&
                       bus_addr_i == ADDR_W'(EN_CLR_BASE + WORD_BYTES * (i / WORD_BITS));
      end
      for (int j = 0; j < NUM_SEC; j++) begin
         sec_pclr[j] = bus_wr_i && bus_wdata_i[j] && bus_addr_i == ADDR_W'(SEC_PCLR);
         sec_eset[j] = bus_wr_i && bus_wdata_i[j] && bus_addr_i == ADDR_W'(SEC_ESET);
         sec_eclr[j] = bus_wr_i && bus_wdata_i[j] && bus_addr_i == ADDR_W'(SEC_ECLR);
      end
   end

   logic             map_hit;
   logic [SEL_W-1:0] map_sel;

   always_comb begin
      map_hit = 1'b0;
      map_sel = '0;
      for (int ch = 0; ch < NUM_PRI; ch++) begin
         if (bus_addr_i == ADDR_W'(MAP_BASE + WORD_BYTES * ch)) begin
            map_hit = 1'b1;
            map_sel = SEL_W'(ch);
         end
      end
   end

   // ---------------- banks ----------------
   logic [NUM_PRI-1:0] pri_pend, pri_en, pri_active;
   logic [NUM_SEC-1:0] sec_pend, sec_en, sec_active;

   irqc_bank #(.WIDTH(NUM_SEC)) u_sec_bank (
      .clk(clk), .rst_n(rst_n), .rise_i(sec_rise), .pend_clr_i(sec_pclr),
      .en_set_i(sec_eset), .en_clr_i(sec_eclr),
      .pend_o(sec_pend), .en_o(sec_en), .active_o(sec_active));

   assign sec_any = |sec_active;

   irqc_bank #(.WIDTH(NUM_PRI)) u_pri_bank (
      .clk(clk), .rst_n(rst_n), .rise_i({pri_rise_ext, casc_rise}),
      .pend_clr_i(pri_pclr), .en_set_i(pri_eset), .en_clr_i(pri_eclr),
      .pend_o(pri_pend), .en_o(pri_en), .active_o(pri_active));

   // ---------------- arbitration ----------------
   logic [IDX_W-1:0] win_idx;
   logic             win_valid;

   irqc_prio #(.WIDTH(NUM_PRI), .IDX_W(IDX_W)) u_prio (
      .clk(clk), .rst_n(rst_n), .req_i(pri_active), .idx_o(win_idx), .valid_o(win_valid));

   assign irq_o = |pri_active;

   // ---------------- channel table ----------------
   logic [IDX_W-1:0] map_rd;

   irqc_chan_map #(.NUM_CH(NUM_PRI), .FIELD_W(IDX_W)) u_map (
      .clk(clk), .rst_n(rst_n), .wr_en_i(bus_wr_i && map_hit), .wr_sel_i(map_sel),
      .wr_data_i(bus_wdata_i[IDX_W-1:0]), .rd_sel_i(map_sel), .rd_data_o(map_rd));

   // ---------------- read path ----------------
   logic [PAD_W-1:0] pend_pad, en_pad;
   logic [31:0]      rd_next;
   logic [31:0]      rdata_q;

   assign pend_pad = PAD_W'(pri_pend);
   assign en_pad   = PAD_W'(pri_en);

   always_comb begin
      rd_next = '0;
      for (int w = 0; w < PRI_WORDS; w++) begin
         if (bus_addr_i == ADDR_W'(PEND_BASE + WORD_BYTES * w))
            rd_next = pend_pad[w*WORD_BITS +: WORD_BITS];
         if (bus_addr_i == ADDR_W'(EN_SET_BASE + WORD_BYTES * w) ||
             bus_addr_i == ADDR_W'(EN_CLR_BASE + WORD_BYTES * w))
            rd_next = en_pad[w*WORD_BITS +: WORD_BITS];
      end
      if (bus_addr_i == ADDR_W'(INDEX_ADDR)) rd_next = 32'(win_idx);
      if (bus_addr_i == ADDR_W'(SEC_STATUS)) rd_next = 32'(sec_pend);
      if (bus_addr_i == ADDR_W'(SEC_ESET) || bus_addr_i == ADDR_W'(SEC_ECLR))
         rd_next = 32'(sec_en);
      if (map_hit) rd_next = 32'(map_rd);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata_q <= '0;
      else if (bus_rd_i) rdata_q <= rd_next;
   end

   assign bus_rdata_o = rdata_q;

   // ---------------- checks ----------------
   assert_cascade_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sec_any) |=> pri_pend[0]);

   assert_irq_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == win_valid);

   assert_irq_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (win_idx == '1));
endmodule

// File: tb/cascade_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [39:1] pri_src = '0;
   logic [31:0] sec_src = '0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [31:0] rdata;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   cascade_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .pri_src_i(pri_src), .sec_src_i(sec_src),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_wr_i(wr), .bus_rd_i(rd),
      .bus_rdata_o(rdata), .irq_o(irq));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic read_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      chk(tag, d, exp);
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic quiesce();
      pri_src = '0; sec_src = '0;
      bus_write(12'h030, 32'hFFFF_FFFF);
      bus_write(12'h034, 32'hFFFF_FFFF);
      bus_write(12'h098, 32'hFFFF_FFFF);
      settle(6);
      bus_write(12'h010, 32'hFFFF_FFFF);
      bus_write(12'h014, 32'hFFFF_FFFF);
      bus_write(12'h088, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      read_chk("R1 pend w0", 12'h010, 32'h0);
      read_chk("R1 pend w1", 12'h014, 32'h0);
      read_chk("R1 en w0", 12'h020, 32'h0);
      read_chk("R1 en w1", 12'h024, 32'h0);
      read_chk("R1 sec status", 12'h080, 32'h0);
      read_chk("R1 sec en", 12'h090, 32'h0);
      read_chk("R1 index idle", 12'h040, 32'd63);
      chk("R1 irq low", {31'b0, irq}, 32'h0);
      read_chk("R10 map ch0", 12'h200, 32'd0);
      read_chk("R10 map ch17", 12'h244, 32'd17);
      read_chk("R10 map ch39", 12'h29C, 32'd39);
   endtask

   task automatic t_enable();
      bus_write(12'h020, 32'h0000_0A00);
      read_chk("R3 set w0", 12'h020, 32'h0000_0A00);
      bus_write(12'h020, 32'h0000_0000);
      read_chk("R3 zero set no effect", 12'h020, 32'h0000_0A00);
      bus_write(12'h030, 32'h0000_0800);
      read_chk("R3 clr w0", 12'h020, 32'h0000_0200);
      read_chk("R3 clr addr reads en", 12'h030, 32'h0000_0200);
      bus_write(12'h024, 32'hFFFF_FFFF);
      read_chk("R4 w1 only 8 bits", 12'h024, 32'h0000_00FF);
      bus_write(12'h034, 32'h0000_000F);
      read_chk("R3 clr w1", 12'h034, 32'h0000_00F0);
      quiesce();
   endtask

   task automatic t_pending();
      pri_src[5] = 1'b1;
      settle(4);
      read_chk("R2 pend line5", 12'h010, 32'h0000_0020);
      chk("R7 disabled no irq", {31'b0, irq}, 32'h0);
      read_chk("R6 disabled idle", 12'h040, 32'd63);
      bus_write(12'h020, 32'h0000_0020);
      chk("R7 irq on enable", {31'b0, irq}, 32'h1);
      read_chk("R6 index 5", 12'h040, 32'd5);
      pri_src[36] = 1'b1;
      settle(4);
      read_chk("R4 line36 word1 bit4", 12'h014, 32'h0000_0010);
      bus_write(12'h024, 32'h0000_0010);
      read_chk("R6 lower wins across words", 12'h040, 32'd5);
      bus_write(12'h010, 32'h0000_0020);
      settle(4);
      read_chk("R2 level no relatch", 12'h010, 32'h0);
      read_chk("R6 next is 36", 12'h040, 32'd36);
      bus_write(12'h014, 32'h0000_0010);
      read_chk("R6 idle after clear", 12'h040, 32'd63);
      chk("R7 irq low after clear", {31'b0, irq}, 32'h0);
      pri_src[5] = 1'b0;
      settle(4);
      pri_src[5] = 1'b1;
      settle(4);
      read_chk("R2 new edge relatch", 12'h010, 32'h0000_0020);
      quiesce();
   endtask

   task automatic t_priority();
      bus_write(12'h020, 32'hFFFF_FFFF);
      bus_write(12'h024, 32'h0000_00FF);
      pri_src[39] = 1'b1; pri_src[20] = 1'b1; pri_src[7] = 1'b1;
      settle(4);
      read_chk("R6 three lines -> 7", 12'h040, 32'd7);
      bus_write(12'h010, 32'h0000_0080);
      read_chk("R6 then 20", 12'h040, 32'd20);
      bus_write(12'h010, 32'h0010_0000);
      read_chk("R6 then 39", 12'h040, 32'd39);
      bus_write(12'h014, 32'h0000_0080);
      read_chk("R6 then idle", 12'h040, 32'd63);
      quiesce();
   endtask

   task automatic t_edge_vs_clear();
      pri_src[10] = 1'b1;
      settle(4);
      pri_src[10] = 1'b0;
      settle(4);
      read_chk("R2 held after source drops", 12'h010, 32'h0000_0400);
      @(negedge clk);
      pri_src[10] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      bus_write(12'h010, 32'h0000_0400);
      read_chk("R5 edge beats clear", 12'h010, 32'h0000_0400);
      bus_write(12'h010, 32'h0000_0400);
      read_chk("R4 plain clear", 12'h010, 32'h0);
      quiesce();
   endtask

   task automatic t_secondary();
      bus_write(12'h020, 32'h0000_0001);
      sec_src[3] = 1'b1;
      settle(4);
      read_chk("R8 sec status", 12'h080, 32'h0000_0008);
      read_chk("R9 no cascade while sec disabled", 12'h010, 32'h0);
      bus_write(12'h090, 32'h0000_0008);
      settle(3);
      read_chk("R8 sec en set", 12'h090, 32'h0000_0008);
      read_chk("R8 sec en via clr addr", 12'h098, 32'h0000_0008);
      read_chk("R9 line0 pending", 12'h010, 32'h0000_0001);
      read_chk("R9 index 0", 12'h040, 32'd0);
      chk("R9 irq via cascade", {31'b0, irq}, 32'h1);
      bus_write(12'h088, 32'h0000_0008);
      settle(4);
      read_chk("R8 sec clear no relatch", 12'h080, 32'h0);
      bus_write(12'h010, 32'h0000_0001);
      read_chk("R9 line0 cleared", 12'h040, 32'd63);
      bus_write(12'h098, 32'h0000_0008);
      read_chk("R8 sec en clr", 12'h090, 32'h0);
      quiesce();
   endtask

   task automatic t_chan_map();
      bus_write(12'h230, 32'hFFFF_FF2A);
      read_chk("R10 map write ch12", 12'h230, 32'h0000_002A);
      read_chk("R10 map neighbour ch13", 12'h234, 32'd13);
   endtask

   task automatic t_unmapped();
      bus_write(12'h020, 32'h0000_0100);
      bus_write(12'h044, 32'hFFFF_FFFF);
      bus_write(12'h018, 32'hFFFF_FFFF);
      bus_write(12'h028, 32'hFFFF_FFFF);
      bus_write(12'h084, 32'hFFFF_FFFF);
      bus_write(12'h201, 32'h0000_0015);
      read_chk("R11 en unchanged", 12'h020, 32'h0000_0100);
      read_chk("R11 sec en unchanged", 12'h090, 32'h0);
      read_chk("R11 map ch0 unchanged", 12'h200, 32'd0);
      read_chk("R11 read 0x44", 12'h044, 32'h0);
      read_chk("R11 read past table", 12'h2A0, 32'h0);
      quiesce();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all R) actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle(2);
      t_reset();
      t_enable();
      t_pending();
      t_priority();
      t_edge_vs_clear();
      t_secondary();
      t_chan_map();
      t_unmapped();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule